// File: doc/BRIEF.md
# Serial Identifier CRC-8 Checker

This block validates a 64-bit device identifier that has already been sampled
off a single-wire bus. The bus front end hands over one bit at a time, each
marked by a strobe. A clear starts a new read. The block then folds every
accepted bit into a reflected 8-bit CRC register with generator
x^8 + x^5 + x^4 + 1. At the same time it stores each bit at its own position
in the identifier.

The identifier carries its check byte as its last eight bits. A correct read
therefore leaves the register at zero once all 64 bits have gone in. When the
64th bit arrives, the block pulses a done flag for one cycle. From then on it
holds a pass flag and the three captured fields: a leading type byte, a 48-bit
serial number and the received check byte. It also holds the CRC it computed
over the first 56 bits, so that value can be compared with the received check
byte. An abort returns the block to idle at any point.

Top module: `owid_crc_check`

## Requirements
- R1: After reset, done, pass, crc_calc, family, serial and crc_rx are all zero. The block is idle, and bits strobed before the first clear have no effect on any output.
- R2: A cycle with clear high (and abort low) sets the bit count, the CRC register, the captured fields, crc_calc and pass to zero, and starts accepting bits. A bit strobed in the same cycle as clear is discarded.
- R3: For each accepted bit b, with register r, the feedback is f = b XOR r[0]. The new register is r shifted right by one, XORed with 8'h8C when f is 1. The register starts at 8'h00.
- R4: Bits arrive least significant bit first, and the n-th accepted bit (n from 0) is stored at identifier bit n. So family = bits 7:0 (byte 0), serial = bits 55:8 (byte 1 in serial[7:0]), and crc_rx = bits 63:56 (byte 7).
- R5: On the edge that accepts the 56th bit, crc_calc takes the register value including that bit, and holds it until the next clear or abort. The bytes 02, 1C, B8, 01, 00, 00, 00 give crc_calc = 8'hA2.
- R6: done is high for exactly the one cycle after the edge that accepts the 64th bit. pass becomes 1 on that edge if the register including bit 64 is 8'h00, and 0 otherwise. pass holds until the next clear or abort. The identifier A2000000_01B81C02 (hex, byte 7 first) passes. The same identifier with any single bit flipped fails.
- R7: After the 64th bit, further strobed bits change no output until the next clear.
- R8: Cycles with bit_valid low insert no bit, so any number of idle cycles between bits leaves the result unchanged.
- R9: abort has priority over clear. It zeroes done, pass, crc_calc, the fields and the count, and returns the block to idle, where bits are ignored until the next clear.
- R10: If the 8 bits after the 56 data bits are the ones' complement of crc_calc, the read fails (the residue is 8'h35, which is not zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Start a new identifier read |
| abort | input | 1 | Return to idle and discard the read |
| bit_valid | input | 1 | bit_in carries a sampled bit this cycle |
| bit_in | input | 1 | Sampled identifier bit |
| done | output | 1 | One-cycle pulse after the 64th bit |
| pass | output | 1 | Residue was zero at the end of the read |
| family | output | 8 | Captured byte 0 |
| serial | output | 48 | Captured bytes 1 to 6 |
| crc_rx | output | 8 | Captured byte 7 (received check byte) |
| crc_calc | output | 8 | CRC computed over the first 56 bits |

## Verification
The hardest conditions to reach from the ports are those where control inputs collide with bit strobes. These are a clear or abort in the same cycle as a valid bit, bits arriving while idle or after the 64th bit, and a complement check byte that yields a nonzero but fixed residue. The stimulus drives these collisions directly. It mixes in reads with pseudo-random idle gaps, runs several identifiers whose check byte the bench computes itself, and runs an all-zero identifier. A behavioural model, kept as integers and indexed arrays, is compared with every output on every cycle.

// File: rtl/owid_pkg.sv
package owid_pkg;
  localparam int unsigned OWID_CRC_W = 8;

  function automatic logic [OWID_CRC_W-1:0] crc_refl_step(
    input logic [OWID_CRC_W-1:0] r,
    input logic                  b,
    input logic [OWID_CRC_W-1:0] poly_refl
  );
    logic fb;
    logic [OWID_CRC_W-1:0] s;
    fb = b ^ r[0];
    s  = r >> 1;
    if (fb) s = s ^ poly_refl;
    return s;
  endfunction
endpackage

// File: rtl/owid_seq_ctrl.sv
module owid_seq_ctrl #(
  parameter int unsigned ID_BITS   = 64,
  parameter int unsigned DATA_BITS = 56,
  localparam int unsigned CW = $clog2(ID_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          abort,
  input  logic          bit_valid,
  output logic          active,
  output logic          accept,
  output logic [CW-1:0] pos,
  output logic          data_end,
  output logic          id_end
);
  logic          active_q;
  logic [CW-1:0] pos_q;

  assign active   = active_q;
  assign pos      = pos_q;
  assign accept   = active_q & bit_valid & ~clear & ~abort;
  assign data_end = accept & (pos_q == CW'(DATA_BITS - 1));
  assign id_end   = accept & (pos_q == CW'(ID_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pos_q    <= '0;
    end else if (abort) begin
      active_q <= 1'b0;
      pos_q    <= '0;
    end else if (clear) begin
      active_q <= 1'b1;
      pos_q    <= '0;
    end else if (accept) begin
      pos_q <= pos_q + 1'b1;
      if (id_end) active_q <= 1'b0;
    end
  end

  assert_pos_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= CW'(ID_BITS));

  assert_idle_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !clear && !abort) |=> $stable(pos_q) && !active_q);

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !active_q && pos_q == '0);
endmodule

// File: rtl/owid_crc_reg.sv
module owid_crc_reg
  import owid_pkg::*;
#(
  parameter int unsigned W = OWID_CRC_W,
  parameter logic [W-1:0] POLY_REFL = 8'h8C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] crc_q,
  output logic [W-1:0] crc_next
);
  assign crc_next = crc_refl_step(crc_q, bit_in, POLY_REFL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        crc_q <= '0;
    else if (restart)  crc_q <= '0;
    else if (shift_en) crc_q <= crc_next;
  end

  assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> crc_q == '0);

  assert_hold_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !shift_en) |=> $stable(crc_q));
endmodule

// File: rtl/owid_field_cap.sv
module owid_field_cap #(
  parameter int unsigned ID_BITS = 64,
  localparam int unsigned CW = $clog2(ID_BITS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               wr_en,
  input  logic [CW-1:0]      pos,
  input  logic               bit_in,
  output logic [ID_BITS-1:0] id_q
);
  for (genvar i = 0; i < ID_BITS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            id_q[i] <= 1'b0;
      else if (restart)                      id_q[i] <= 1'b0;
      else if (wr_en && pos == CW'(i))       id_q[i] <= bit_in;
    end
  end

  assert_cap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !wr_en) |=> $stable(id_q));
endmodule

// File: rtl/owid_crc_check.sv
module owid_crc_check
  import owid_pkg::*;
#(
  parameter int unsigned ID_BITS = 64,
  parameter int unsigned FAM_W   = 8,
  parameter int unsigned CRC_W   = OWID_CRC_W,
  parameter logic [CRC_W-1:0] POLY_REFL = 8'h8C,
  localparam int unsigned DATA_BITS = ID_BITS - CRC_W,
  localparam int unsigned SER_W     = DATA_BITS - FAM_W,
  localparam int unsigned CW        = $clog2(ID_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             abort,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic             done,
  output logic             pass,
  output logic [FAM_W-1:0] family,
  output logic [SER_W-1:0] serial,
  output logic [CRC_W-1:0] crc_rx,
  output logic [CRC_W-1:0] crc_calc
);
  logic               active, accept, data_end, id_end, restart;
  logic [CW-1:0]      pos;
  logic [CRC_W-1:0]   crc_q, crc_next;
  logic [ID_BITS-1:0] id_q;
  logic               done_q, pass_q;
  logic [CRC_W-1:0]   calc_q;

  assign restart = clear | abort;

  owid_seq_ctrl #(.ID_BITS(ID_BITS), .DATA_BITS(DATA_BITS)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .clear(clear), .abort(abort),
    .bit_valid(bit_valid), .active(active), .accept(accept), .pos(pos),
    .data_end(data_end), .id_end(id_end)
  );

  owid_crc_reg #(.W(CRC_W), .POLY_REFL(POLY_REFL)) i_crc (
    .clk(clk), .rst_n(rst_n), .restart(restart), .shift_en(accept),
    .bit_in(bit_in), .crc_q(crc_q), .crc_next(crc_next)
  );

  owid_field_cap #(.ID_BITS(ID_BITS)) i_cap (
    .clk(clk), .rst_n(rst_n), .restart(restart), .wr_en(accept),
    .pos(pos), .bit_in(bit_in), .id_q(id_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      calc_q <= '0;
    end else if (restart) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      calc_q <= '0;
    end else begin
      done_q <= id_end;
      if (id_end)   pass_q <= (crc_next == '0);
      if (data_end) calc_q <= crc_next;
    end
  end

  assign done     = done_q;
  assign pass     = pass_q;
  assign crc_calc = calc_q;
  assign family   = id_q[FAM_W-1:0];
  assign serial   = id_q[DATA_BITS-1:FAM_W];
  assign crc_rx   = id_q[ID_BITS-1:DATA_BITS];

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(accept));

  assert_pass_residue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (pass_q == (crc_q == '0)));

  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !done_q && !pass_q && calc_q == '0);

  assert_calc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !data_end) |=> $stable(calc_q));

  assert_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !restart) |=> $stable(crc_q) && $stable(id_q) && $stable(pass_q));
endmodule

// File: tb/test_owid_crc_check.sv
module test_owid_crc_check;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, abort = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic done, pass;
  logic [7:0]  family, crc_rx, crc_calc;
  logic [47:0] serial;

  always #2 clk = ~clk;

  owid_crc_check i_owid_crc_check (
    .clk(clk), .rst_n(rst_n), .clear(clear), .abort(abort),
    .bit_valid(bit_valid), .bit_in(bit_in), .done(done), .pass(pass),
    .family(family), .serial(serial), .crc_rx(crc_rx), .crc_calc(crc_calc)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  bit cmp_on = 1'b0;

  // behavioural reference model
  bit        m_active;
  int        m_cnt;
  bit [7:0]  m_crc;
  bit        m_done, m_pass;
  bit [7:0]  m_calc;
  bit        m_id [64];

  function automatic bit [7:0] m_step(bit [7:0] r, bit b);
    bit f;
    bit [7:0] n;
    f = b ^ r[0];
    for (int k = 0; k < 7; k++) n[k] = r[k+1];
    n[7] = f;
    n[3] = r[4] ^ f;
    n[2] = r[3] ^ f;
    return n;
  endfunction

  function automatic bit [7:0] bytes_crc(bit [63:0] v, int nbytes);
    bit [7:0] r;
    r = 8'h00;
    for (int j = 0; j < nbytes; j++) begin
      r = r ^ v[j*8 +: 8];
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 8'h8C) : (r >> 1);
    end
    return r;
  endfunction

  task automatic model_wipe();
    m_cnt = 0; m_crc = 0; m_done = 0; m_pass = 0; m_calc = 0;
    for (int k = 0; k < 64; k++) m_id[k] = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; model_wipe();
    end else if (abort) begin
      m_active = 0; model_wipe();
    end else if (clear) begin
      m_active = 1; model_wipe();
    end else begin
      m_done = 0;
      if (m_active && bit_valid) begin
        m_crc = m_step(m_crc, bit_in);
        m_id[m_cnt] = bit_in;
        m_cnt++;
        if (m_cnt == 56) m_calc = m_crc;
        if (m_cnt == 64) begin
          m_done = 1; m_pass = (m_crc == 0); m_active = 0;
        end
      end
    end
  end

  function automatic bit [63:0] m_idvec();
    bit [63:0] v;
    for (int k = 0; k < 64; k++) v[k] = m_id[k];
    return v;
  endfunction

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      bit [63:0] v;
      v = m_idvec();
      vectors++;
      if (done !== m_done) begin miscompares++; $display("FAIL R6 done act=%0b exp=%0b", done, m_done); end
      if (pass !== m_pass) begin miscompares++; $display("FAIL R6 pass act=%0b exp=%0b", pass, m_pass); end
      if (crc_calc !== m_calc) begin miscompares++; $display("FAIL R5 crc_calc act=%h exp=%h", crc_calc, m_calc); end
      if ({crc_rx, serial, family} !== v) begin
        miscompares++; $display("FAIL R4 fields act=%h exp=%h", {crc_rx, serial, family}, v);
      end
    end
  end

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic tick(logic v, logic b, logic c, logic a);
    @(negedge clk);
    bit_valid = v; bit_in = b; clear = c; abort = a;
  endtask

  bit [15:0] lfsr = 16'hACE1;
  function automatic int next_gap();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr[1:0]);
  endfunction

  task automatic send_id(bit [63:0] id, bit gaps);
    tick(0, 0, 1, 0);
    for (int i = 0; i < 64; i++) begin
      if (gaps) begin
        int g;
        g = next_gap();
        for (int q = 0; q < g; q++) tick(0, 1, 0, 0);
      end
      tick(1, id[i], 0, 0);
    end
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 0);
  endtask

  localparam bit [63:0] GOLD = 64'hA2000000_01B81C02;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    bit [63:0] id;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!done && !pass && crc_calc == 0 && family == 0 && serial == 0 && crc_rx == 0,
          "R1 reset outputs", {done, pass, crc_calc, family}, 0);
    // R1: bits before the first clear are ignored
    for (int i = 0; i < 70; i++) tick(1, 1, 0, 0);
    tick(0, 0, 0, 0);
    check(!done && family == 0 && crc_calc == 0, "R1 idle ignores bits", {family, crc_calc}, 0);

    // R3 R4 R5 R6: known identifier, no gaps
    send_id(GOLD, 0);
    check(crc_calc == 8'hA2, "R5 computed crc", crc_calc, 8'hA2);
    check(pass == 1'b1, "R6 gold passes", pass, 1);
    check(family == 8'h02 && serial == 48'h00000001B81C && crc_rx == 8'hA2,
          "R4 field order", {crc_rx, serial, family}, GOLD);

    // R7: extra bits after 64 ignored
    for (int i = 0; i < 10; i++) tick(1, i[0], 0, 0);
    tick(0, 0, 0, 0);
    check(pass == 1'b1 && crc_rx == 8'hA2, "R7 extra bits ignored", {pass, crc_rx}, {1'b1, 8'hA2});

    // R6: single flipped bit fails
    send_id(GOLD ^ (64'd1 << 20), 0);
    check(pass == 1'b0, "R6 corrupted fails", pass, 0);

    // R8: gaps between bits
    send_id(GOLD, 1);
    check(pass == 1'b1 && crc_calc == 8'hA2, "R8 gapped read", {pass, crc_calc}, {1'b1, 8'hA2});

    // R3: identifiers with bench-computed check byte
    for (int n = 0; n < 5; n++) begin
      id = {8'h00, 8'(n * 37 + 5), 8'h5A ^ 8'(n), 8'hC3, 8'(n), 8'h96, 8'h0F + 8'(n), 8'h28};
      id[63:56] = bytes_crc(id, 7);
      send_id(id, n[0]);
      check(pass == 1'b1 && crc_calc == id[63:56], "R3 computed id passes",
            {pass, crc_calc}, {1'b1, id[63:56]});
    end

    // R10: complement check byte fails
    id = GOLD;
    id[63:56] = ~bytes_crc(id, 7);
    send_id(id, 0);
    check(pass == 1'b0 && crc_calc == 8'hA2, "R10 complement fails", {pass, crc_calc}, {1'b0, 8'hA2});

    // all-zero identifier has zero residue
    send_id(64'd0, 0);
    check(pass == 1'b1, "R6 all-zero passes", pass, 1);

    // R9: abort mid-read, then bits ignored
    tick(0, 0, 1, 0);
    for (int i = 0; i < 30; i++) tick(1, GOLD[i], 0, 0);
    tick(1, 1, 0, 1);
    for (int i = 0; i < 40; i++) tick(1, 1, 0, 0);
    tick(0, 0, 0, 0);
    check(!done && !pass && family == 0 && crc_calc == 0, "R9 abort idles", {pass, family}, 0);
    // R9: abort beats clear
    tick(0, 0, 1, 1);
    for (int i = 0; i < 8; i++) tick(1, 1, 0, 0);
    tick(0, 0, 0, 0);
    check(family == 0, "R9 abort over clear", family, 0);

    // R2: clear mid-read restarts; bit with clear is discarded
    tick(0, 0, 1, 0);
    for (int i = 0; i < 20; i++) tick(1, 1, 0, 0);
    tick(1, 1, 1, 0);
    for (int i = 0; i < 64; i++) tick(1, GOLD[i], 0, 0);
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 0);
    check(pass == 1'b1 && family == 8'h02, "R2 restart mid-read", {pass, family}, {1'b1, 8'h02});

    tick(0, 0, 0, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule